// File: doc/BRIEF.md
# Tick-Driven Watchdog Timer with APB Register Access

This block is a down-counting watchdog that sits on an APB slave port. Software writes a reload value and then sets the run bit in the control register. From then on, every cycle in which `tick_en` is high moves the count down by one. When the count runs out, the block latches a raw interrupt flag and reloads itself from the reload register. If that flag is still set when the count runs out a second time, and the reset-request bit is set, the block raises `rst_req_o`. The line stays high until the next reset.

Control bit 0 has two jobs. It gates the counter, and it masks the interrupt. Clearing it freezes the count where it stands. Setting it again reloads the count at once. Writing the reload register always restarts the count from the new value, whether or not the counter is running. A build-time parameter selects a locked variant. In that variant, once bit 0 has been set, every later control write is dropped until reset, so the watchdog cannot be switched off by software.

The register map, as byte offsets:

| Offset | Register | Access | Contents |
|---|---|---|---|
| 0x00 | reload | read/write | reload value |
| 0x04 | count | read-only | current count |
| 0x08 | control | read/write | bit 0 = run and interrupt enable, bit 1 = reset-request enable |
| 0x0C | clear | write-only | any write clears the raw flag and reloads the count |
| 0x10 | raw status | read-only | bit 0 = raw flag |
| 0x14 | masked status | read-only | bit 0 = raw flag AND run bit |

All other offsets read as zero. Every transfer completes with no wait states.

Top module: `tick_watchdog`

## Requirements
- R1: After reset, the reload register and the count both read 32'hFFFF_FFFF, control reads 0, raw and masked status read 0, and `irq_o` and `rst_req_o` are low.
- R2: While control bit 0 is 0, ticks never change the count.
- R3: A write to offset 0x00 stores the value, and the count reads that same value right after the write, whether the counter is running or not.
- R4: While control bit 0 is 1, each tick lowers the count by exactly one (for example, a reload of 3000 reads 2000 after 1000 ticks). Cycles without a tick leave the count unchanged.
- R5: Writing 0 to control bit 0 freezes the count at its present value and leaves the reload register and the raw status unchanged.
- R6: Writing control bit 0 to 1 when it was 0 reloads the count from the reload register in that same write.
- R7: A tick that arrives while the count reads 1 (or 0) sets raw status bit 0 and reloads the count from the reload register. Before that tick, raw status reads 0 even though the count reads 1. With reload value L ≥ 1, after k ticks the count reads L − (k mod L). With L = 0, it stays 0.
- R8: Masked status bit 0 (offset 0x14) and `irq_o` both equal raw status AND control bit 0.
- R9: Any write to offset 0x0C clears raw status and reloads the count from the reload register.
- R10: An expiry that arrives while raw status is already 1 and control bit 1 is 1 drives `rst_req_o` high, and it stays high until reset. If control bit 1 is 0, `rst_req_o` stays low.
- R11: With `LOCK_EN` = 1, once control bit 0 reads 1, every control write is ignored until reset: control keeps reading 0x1 and the counter keeps running. After reset, control reads 0 and the counter is idle.
- R12: `pready` is always 1 and `pslverr` is always 0. Reads of unmapped offsets and of offset 0x0C return 0. Writes to offset 0x04 do not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | APB read data |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| tick_en | input | 1 | Count step strobe, one step per high cycle |
| irq_o | output | 1 | Masked interrupt |
| rst_req_o | output | 1 | Sticky reset request |

## Verification
The count is driven with long runs that switch between enabled and disabled, so that a freeze can be told apart from a reload. A write to the reload register is also applied in each enable state.

A sweep covers reload values 0 to 5, applying every tick count from zero up to two periods plus two. Each point is compared against L − (k mod L), which separates an off-by-one expiry from a correct one. The same sweep checks where the raw flag and the reset request first rise.

A separate instance built with the locked variant receives disable writes and mixed control writes. These show that the lock holds until reset and that reset releases it.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // Byte offsets of the register file
  localparam int unsigned OFS_LOAD   = 32'h00;
  localparam int unsigned OFS_VALUE  = 32'h04;
  localparam int unsigned OFS_CTRL   = 32'h08;
  localparam int unsigned OFS_CLEAR  = 32'h0C;
  localparam int unsigned OFS_RAW    = 32'h10;
  localparam int unsigned OFS_MASKED = 32'h14;

  // Control register: bit 0 run/interrupt enable, bit 1 reset-request enable
  typedef struct packed {
    logic rst_en;
    logic run_en;
  } wdog_ctrl_t;

  typedef enum logic [2:0] {
    RS_LOAD,
    RS_VALUE,
    RS_CTRL,
    RS_CLEAR,
    RS_RAW,
    RS_MASKED,
    RS_NONE
  } wdog_reg_e;

endpackage

// File: rtl/wdog_apb_port.sv
module wdog_apb_port
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] load_q,
  input  logic [DATA_W-1:0] count_q,
  input  wdog_ctrl_t        ctrl_q,
  input  logic              ris_q,
  input  logic              mis,
  output logic [DATA_W-1:0] prdata,
  output logic              wr_load,
  output logic              wr_ctrl,
  output logic              wr_clr
);

  localparam logic [ADDR_W-1:0] A_LOAD   = ADDR_W'(OFS_LOAD);
  localparam logic [ADDR_W-1:0] A_VALUE  = ADDR_W'(OFS_VALUE);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_CLEAR  = ADDR_W'(OFS_CLEAR);
  localparam logic [ADDR_W-1:0] A_RAW    = ADDR_W'(OFS_RAW);
  localparam logic [ADDR_W-1:0] A_MASKED = ADDR_W'(OFS_MASKED);
  localparam int                CTRL_W   = $bits(wdog_ctrl_t);

  wdog_reg_e sel;
  logic      wr_acc;

  always_comb begin
    case (paddr)
      A_LOAD:   sel = RS_LOAD;
      A_VALUE:  sel = RS_VALUE;
      A_CTRL:   sel = RS_CTRL;
      A_CLEAR:  sel = RS_CLEAR;
      A_RAW:    sel = RS_RAW;
      A_MASKED: sel = RS_MASKED;
      default:  sel = RS_NONE;
    endcase
  end

  // Zero-wait access: the write takes effect in the access phase
  assign wr_acc  = psel & penable & pwrite;
  assign wr_load = wr_acc & (sel == RS_LOAD);
  assign wr_ctrl = wr_acc & (sel == RS_CTRL);
  assign wr_clr  = wr_acc & (sel == RS_CLEAR);

  always_comb begin
    case (sel)
      RS_LOAD:   prdata = load_q;
      RS_VALUE:  prdata = count_q;
      RS_CTRL:   prdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
      RS_RAW:    prdata = {{(DATA_W-1){1'b0}}, ris_q};
      RS_MASKED: prdata = {{(DATA_W-1){1'b0}}, mis};
      default:   prdata = '0;
    endcase
  end

endmodule

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg
  import wdog_pkg::*;
#(
  parameter bit LOCK_EN = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ctrl,
  input  wdog_ctrl_t wdata,
  output wdog_ctrl_t ctrl_q,
  output logic       en_rise
);

  logic accept;

  generate
    if (LOCK_EN) begin : g_locking
      // Once running, the register refuses every write until reset
      assign accept = wr_ctrl & ~ctrl_q.run_en;
    end else begin : g_free
      assign accept = wr_ctrl;
    end
  endgenerate

  assign en_rise = accept & wdata.run_en & ~ctrl_q.run_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (accept) begin
      ctrl_q <= wdata;
    end
  end

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int                DATA_W   = 32,
  parameter logic [DATA_W-1:0] LOAD_DEF = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_load,
  input  logic [DATA_W-1:0] wdata,
  input  logic              reload_req,
  input  logic              run_en,
  input  logic              tick_en,
  output logic [DATA_W-1:0] load_q,
  output logic [DATA_W-1:0] count_q,
  output logic              expire
);

  logic at_end;
  logic step;

  // The last step is taken from 1 (or from 0 when the reload value is zero)
  assign at_end = (count_q[DATA_W-1:1] == '0);
  assign step   = run_en & tick_en & ~wr_load & ~reload_req;
  assign expire = step & at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q  <= LOAD_DEF;
      count_q <= LOAD_DEF;
    end else if (wr_load) begin
      load_q  <= wdata;
      count_q <= wdata;
    end else if (reload_req) begin
      count_q <= load_q;
    end else if (step) begin
      count_q <= at_end ? load_q : count_q - 1'b1;
    end
  end

endmodule

// File: rtl/wdog_irq.sv
module wdog_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic wr_clr,
  input  logic run_en,
  input  logic rst_en,
  output logic ris_q,
  output logic mis,
  output logic rst_req_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ris_q <= 1'b0;
    end else if (wr_clr) begin
      ris_q <= 1'b0;
    end else if (expire) begin
      ris_q <= 1'b1;
    end
  end

  // A second expiry with the flag still pending requests a reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req_q <= 1'b0;
    end else if (expire & ris_q & rst_en) begin
      rst_req_q <= 1'b1;
    end
  end

  assign mis = ris_q & run_en;

endmodule

// File: rtl/tick_watchdog.sv
module tick_watchdog
  import wdog_pkg::*;
#(
  parameter int                ADDR_W   = 12,
  parameter int                DATA_W   = 32,
  parameter logic [DATA_W-1:0] LOAD_DEF = '1,
  parameter bit                LOCK_EN  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic              tick_en,
  output logic              irq_o,
  output logic              rst_req_o
);

  localparam int CTRL_W = $bits(wdog_ctrl_t);

  logic [DATA_W-1:0] load_q;
  logic [DATA_W-1:0] count_q;
  wdog_ctrl_t        ctrl_q;
  logic              ris_q;
  logic              mis;
  logic              wr_load;
  logic              wr_ctrl;
  logic              wr_clr;
  logic              en_rise;
  logic              expire;
  logic              ctrl_en;

  assign ctrl_en = ctrl_q.run_en;

  wdog_apb_port #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_port (
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .load_q  (load_q),
    .count_q (count_q),
    .ctrl_q  (ctrl_q),
    .ris_q   (ris_q),
    .mis     (mis),
    .prdata  (prdata),
    .wr_load (wr_load),
    .wr_ctrl (wr_ctrl),
    .wr_clr  (wr_clr)
  );

  wdog_ctrl_reg #(
    .LOCK_EN (LOCK_EN)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_ctrl (wr_ctrl),
    .wdata   (wdog_ctrl_t'(pwdata[CTRL_W-1:0])),
    .ctrl_q  (ctrl_q),
    .en_rise (en_rise)
  );

  wdog_counter #(
    .DATA_W   (DATA_W),
    .LOAD_DEF (LOAD_DEF)
  ) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_load    (wr_load),
    .wdata      (pwdata),
    .reload_req (en_rise | wr_clr),
    .run_en     (ctrl_en),
    .tick_en    (tick_en),
    .load_q     (load_q),
    .count_q    (count_q),
    .expire     (expire)
  );

  wdog_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .expire    (expire),
    .wr_clr    (wr_clr),
    .run_en    (ctrl_en),
    .rst_en    (ctrl_q.rst_en),
    .ris_q     (ris_q),
    .mis       (mis),
    .rst_req_q (rst_req_o)
  );

  assign irq_o   = mis;
  assign pready  = 1'b1;
  assign pslverr = 1'b0;

endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter bit LOCK_EN = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [DATA_W-1:0] pwdata,
  input logic              tick_en,
  input logic              irq_o,
  input logic              rst_req_o,
  input logic [DATA_W-1:0] count_q,
  input logic              ctrl_en,
  input logic              ris_q
);

  logic wr_any;
  logic wr_at_load;

  assign wr_any     = psel & penable & pwrite;
  assign wr_at_load = wr_any & (paddr == '0);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_en && !wr_any) |=> $stable(count_q));

  assert_load_sets_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_at_load |=> (count_q == $past(pwdata)));

  assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_en && tick_en && !wr_any && count_q > 1) |=> (count_q == $past(count_q) - 1'b1));

  assert_expiry_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_en && tick_en && !wr_any && count_q <= 1) |=> ris_q);

  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (ctrl_en && ris_q));

  assert_rstreq_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> rst_req_o);

  assert_rstreq_needs_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req_o) |-> $past(ris_q));

  assert_enable_locked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (LOCK_EN && ctrl_en) |=> ctrl_en);

endmodule

bind tick_watchdog wdog_checker #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .LOCK_EN (LOCK_EN)
) u_wdog_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .psel      (psel),
  .penable   (penable),
  .pwrite    (pwrite),
  .paddr     (paddr),
  .pwdata    (pwdata),
  .tick_en   (tick_en),
  .irq_o     (irq_o),
  .rst_req_o (rst_req_o),
  .count_q   (count_q),
  .ctrl_en   (ctrl_en),
  .ris_q     (ris_q)
);

// File: tb/tick_watchdog_bench.sv
module tick_watchdog_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel0 = 1'b0;
  logic        psel1 = 1'b0;
  logic        penable = 1'b0;
  logic        pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic        tick = 1'b0;
  logic [31:0] prdata0, prdata1;
  logic        pready0, pready1, pslverr0, pslverr1;
  logic        irq0, irq1, rr0, rr1;

  int n_chk = 0;
  int n_fail = 0;

  always #4ns clk = ~clk;

  tick_watchdog u_tick_watchdog (
    .clk(clk), .rst_n(rst_n), .psel(psel0), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata0), .pready(pready0),
    .pslverr(pslverr0), .tick_en(tick), .irq_o(irq0), .rst_req_o(rr0)
  );

  tick_watchdog #(.LOCK_EN(1'b1)) u_tick_watchdog_lk (
    .clk(clk), .rst_n(rst_n), .psel(psel1), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata1), .pready(pready1),
    .pslverr(pslverr1), .tick_en(tick), .irq_o(irq1), .rst_req_o(rr1)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic apb_wr(input bit lk, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    psel0 = !lk; psel1 = lk; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk); penable = 1'b1;
    @(negedge clk); psel0 = 1'b0; psel1 = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_rd(input bit lk, input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    psel0 = !lk; psel1 = lk; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge clk); penable = 1'b1;
    #1ns d = lk ? prdata1 : prdata0;
    @(negedge clk); psel0 = 1'b0; psel1 = 1'b0; penable = 1'b0;
  endtask

  task automatic rd_chk(input bit lk, input logic [11:0] a, input string req, input logic [31:0] exp);
    logic [31:0] d;
    apb_rd(lk, a, d);
    chk(req, d, exp);
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk); tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
    end
  endtask

  initial begin
    #1ms;
    n_fail++;
    $display("FAIL watchdog: actual hung run, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    rd_chk(0, 12'h00, "R1 reload default", 32'hFFFF_FFFF);
    rd_chk(0, 12'h04, "R1 count default", 32'hFFFF_FFFF);
    rd_chk(0, 12'h08, "R1 control default", 32'h0);
    rd_chk(0, 12'h10, "R1 raw default", 32'h0);
    rd_chk(0, 12'h14, "R1 masked default", 32'h0);
    chk("R1 irq low", {31'b0, irq0}, 32'h0);
    chk("R1 rst_req low", {31'b0, rr0}, 32'h0);
    // R12 bus response and unmapped reads
    chk("R12 pready", {31'b0, pready0}, 32'h1);
    chk("R12 pslverr", {31'b0, pslverr0}, 32'h0);
    rd_chk(0, 12'h18, "R12 unmapped read", 32'h0);
    rd_chk(0, 12'h0C, "R12 clear reads zero", 32'h0);
    // R2 idle after reset
    ticks(15);
    rd_chk(0, 12'h04, "R2 idle count", 32'hFFFF_FFFF);
    // R3 load while stopped
    apb_wr(0, 12'h00, 32'd4000);
    rd_chk(0, 12'h04, "R3 load stopped", 32'd4000);
    ticks(500);
    rd_chk(0, 12'h04, "R2 stopped after load", 32'd4000);
    // R6 and R4
    apb_wr(0, 12'h08, 32'h1);
    rd_chk(0, 12'h04, "R6 enable reload", 32'd4000);
    ticks(500);
    rd_chk(0, 12'h04, "R4 500 ticks", 32'd3500);
    repeat (20) @(negedge clk);
    rd_chk(0, 12'h04, "R4 no tick no change", 32'd3500);
    // R5 freeze
    apb_wr(0, 12'h08, 32'h0);
    ticks(100);
    rd_chk(0, 12'h04, "R5 frozen count", 32'd3500);
    rd_chk(0, 12'h00, "R5 reload kept", 32'd4000);
    // R6 re-enable reloads
    apb_wr(0, 12'h08, 32'h1);
    rd_chk(0, 12'h04, "R6 re-enable reload", 32'd4000);
    ticks(50);
    rd_chk(0, 12'h04, "R4 50 ticks", 32'd3950);
    // R3 load while running, R7 edge at count 1
    apb_wr(0, 12'h00, 32'd5000);
    rd_chk(0, 12'h04, "R3 load running", 32'd5000);
    ticks(4999);
    rd_chk(0, 12'h04, "R7 count at one", 32'd1);
    rd_chk(0, 12'h10, "R7 raw still clear at one", 32'h0);
    apb_wr(0, 12'h08, 32'h0);
    ticks(10);
    rd_chk(0, 12'h04, "R5 frozen at one", 32'd1);
    rd_chk(0, 12'h10, "R5 raw unchanged", 32'h0);
    // R12 count register is read-only
    apb_wr(0, 12'h04, 32'd123);
    rd_chk(0, 12'h04, "R12 count read-only", 32'd1);
    // 3000 -> 2000 after 1000 ticks
    apb_wr(0, 12'h00, 32'd3000);
    apb_wr(0, 12'h08, 32'h1);
    ticks(1000);
    rd_chk(0, 12'h04, "R4 3000 minus 1000", 32'd2000);

    // Sweep: R7 count and flag, R8 masking, R10 reset request
    for (int L = 0; L <= 5; L++) begin
      for (int k = 0; k <= 2 * L + 2; k++) begin
        int per;
        logic [31:0] exp_cnt;
        per = (L == 0) ? 1 : L;
        exp_cnt = (L == 0) ? 32'd0 : 32'(L - (k % L));
        do_reset();
        apb_wr(0, 12'h00, 32'(L));
        apb_wr(0, 12'h08, 32'h3);
        ticks(k);
        rd_chk(0, 12'h04, "R7 sweep count", exp_cnt);
        rd_chk(0, 12'h10, "R7 sweep raw", {31'b0, k >= per});
        rd_chk(0, 12'h14, "R8 sweep masked", {31'b0, k >= per});
        chk("R8 sweep irq", {31'b0, irq0}, {31'b0, k >= per});
        chk("R10 sweep rst_req", {31'b0, rr0}, {31'b0, k >= 2 * per});
      end
    end

    // R10 without reset enable, R8 masking off, R9 clear
    do_reset();
    apb_wr(0, 12'h00, 32'd2);
    apb_wr(0, 12'h08, 32'h1);
    ticks(7);
    chk("R10 no request without enable", {31'b0, rr0}, 32'h0);
    rd_chk(0, 12'h04, "R7 count after 7 ticks of 2", 32'd1);
    apb_wr(0, 12'h0C, 32'h0);
    rd_chk(0, 12'h10, "R9 clear raw", 32'h0);
    rd_chk(0, 12'h04, "R9 clear reloads", 32'd2);
    ticks(2);
    apb_wr(0, 12'h08, 32'h0);
    rd_chk(0, 12'h10, "R8 raw kept when disabled", 32'h1);
    rd_chk(0, 12'h14, "R8 masked off when disabled", 32'h0);
    chk("R8 irq off when disabled", {31'b0, irq0}, 32'h0);

    // R11 locked variant
    do_reset();
    apb_wr(1, 12'h00, 32'd4000);
    ticks(500);
    rd_chk(1, 12'h04, "R11 idle before enable", 32'd4000);
    apb_wr(1, 12'h08, 32'h1);
    ticks(500);
    rd_chk(1, 12'h04, "R11 running", 32'd3500);
    apb_wr(1, 12'h08, 32'h0);
    ticks(100);
    rd_chk(1, 12'h04, "R11 disable ignored", 32'd3400);
    rd_chk(1, 12'h08, "R11 control stays 1", 32'h1);
    apb_wr(1, 12'h08, 32'h3);
    rd_chk(1, 12'h08, "R11 other write ignored", 32'h1);
    chk("R11 no reset request", {31'b0, rr1}, 32'h0);
    do_reset();
    rd_chk(1, 12'h08, "R11 control after reset", 32'h0);
    rd_chk(1, 12'h04, "R11 count after reset", 32'hFFFF_FFFF);
    ticks(1000);
    rd_chk(1, 12'h04, "R11 idle after reset", 32'hFFFF_FFFF);
    rd_chk(1, 12'h00, "R11 reload after reset", 32'hFFFF_FFFF);
    chk("R11 irq low", {31'b0, irq1}, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule